// File: doc/BRIEF.md
# Multicycle Shared-Port Integer Core

This block is a small 32-bit integer processor that runs one instruction at a time over several clock cycles. It has no pipeline. Instruction fetches and data loads and stores all go through one memory port. A sequencer steps each instruction through named phases. In each phase it decides whether the port address comes from the program counter or from a computed data address, which registers load, and whether the register file is written.

The core holds a program counter, an instruction register, a 32-entry register file whose entry 0 always reads as zero, and an ALU. The memory is outside the block. It must return read data combinationally for the address presented, and it must take a write on the clock edge that ends a cycle in which the write strobe is high.

The sequencer has five states: FETCH, DECODE, EXECUTE, MEMORY and WRITEBACK. Its transitions are:
- FETCH→DECODE, always.
- DECODE→FETCH for an unrecognised instruction.
- DECODE→EXECUTE otherwise.
- EXECUTE→WRITEBACK for ALU operations.
- EXECUTE→MEMORY for loads and stores.
- EXECUTE→FETCH for branches and jumps.
- MEMORY→WRITEBACK for loads.
- MEMORY→FETCH for stores.
- WRITEBACK→FETCH, always.

Top module: `mc_core`

## Requirements
- R1: A synchronous reset sets the program counter to 0 and the sequencer to FETCH. While reset is held, `mem_addr` is 0 and `mem_we` is low.
- R2: Cycle counts per instruction class are:
  - ALU instructions (R-type and immediate): 4 cycles, FETCH, DECODE, EXECUTE, WRITEBACK.
  - Load: 5 cycles, FETCH, DECODE, EXECUTE, MEMORY, WRITEBACK.
  - Store: 4 cycles, FETCH, DECODE, EXECUTE, MEMORY.
  - Branch and jump: 3 cycles, FETCH, DECODE, EXECUTE.
  - Unrecognised instruction: 2 cycles, FETCH, DECODE.
- R3: In FETCH the port address is the program counter. In MEMORY it is the computed data address. `mem_we` is high only in the MEMORY cycle of a store.
- R4: R-type instructions have opcode 0 in bits [31:26]. Their operands are rs in bits [25:21] and rt in bits [20:16], and the destination is rd in bits [15:11]. Function codes in bits [5:0] are add 0x20, sub 0x22, and 0x24, or 0x25 and xor 0x26. Add and subtract wrap modulo 2^32 and never trap.
- R5: Set-less-than (function 0x2A, signed compare) and set-less-than-unsigned (function 0x2B, unsigned compare) write a full word equal to 1 when rs < rt, and 0 otherwise.
- R6: Immediate instructions write rt and take rs and bits [15:0]. Add-immediate (opcode 0x08) sign-extends the immediate. And/or/xor-immediate (opcodes 0x0C, 0x0D, 0x0E) zero-extend it.
- R7: Load word (opcode 0x23) and store word (opcode 0x2B) use the address rs plus the sign-extended offset. A load writes rt; a store sends rt on `mem_wdata`.
- R8: Branch-if-equal (opcode 0x04) and branch-if-not-equal (opcode 0x05) compare rs with rt. When taken, the next PC is the branch's address plus 4 plus the sign-extended offset times 4; when not taken it is the branch's address plus 4.
- R9: Jump (opcode 0x02) sets the PC to bits [31:28] of the jump's address plus 4, followed by bits [25:0] of the instruction, followed by two zero bits.
- R10: Register 0 always reads as zero, and any write to it is discarded.
- R11: Any other opcode, and any R-type function code not listed, acts as a no-op that only advances the PC by 4.
- R12: The instruction register loads only in FETCH. It holds the instruction word through that instruction's remaining cycles, including a load's memory read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 32 | Byte address for the shared memory port |
| mem_wdata | output | 32 | Store data, valid while `mem_we` is high |
| mem_rdata | input | 32 | Combinational read data for `mem_addr` |
| mem_we | output | 1 | High to write, low to read |

## Verification
The bench sweeps every R-type and immediate operation over operand pairs that sit on the sign boundary, wrap on overflow, or hold all ones. A wrong extension choice for an immediate, or an unsigned set-less-than that compares as signed, therefore shows up as a wrong stored word. Branches run on equal and unequal pairs, and one loop uses a negative offset, so an inverted condition or a missing word scaling sends the PC to the wrong instruction. Further tests cover a load and store with a negative offset from a base register, a jump over an instruction, writes to register 0, and undefined encodings. Each test also times the cycle of the final store on the port, which exposes an extra or missing sequencer phase or a write strobe raised outside MEMORY.

// File: rtl/core_pkg.sv
package core_pkg;

    localparam int XLEN  = 32;
    localparam int NREG  = 32;
    localparam int RAW   = $clog2(NREG);
    localparam int IMMW  = 16;
    localparam int JIDXW = 26;
    localparam int OPW   = 6;

    localparam logic [OPW-1:0] OP_RTYPE = 6'h00;
    localparam logic [OPW-1:0] OP_JUMP  = 6'h02;
    localparam logic [OPW-1:0] OP_BEQ   = 6'h04;
    localparam logic [OPW-1:0] OP_BNE   = 6'h05;
    localparam logic [OPW-1:0] OP_ADDI  = 6'h08;
    localparam logic [OPW-1:0] OP_ANDI  = 6'h0C;
    localparam logic [OPW-1:0] OP_ORI   = 6'h0D;
    localparam logic [OPW-1:0] OP_XORI  = 6'h0E;
    localparam logic [OPW-1:0] OP_LOAD  = 6'h23;
    localparam logic [OPW-1:0] OP_STORE = 6'h2B;

    localparam logic [OPW-1:0] FN_ADD  = 6'h20;
    localparam logic [OPW-1:0] FN_SUB  = 6'h22;
    localparam logic [OPW-1:0] FN_AND  = 6'h24;
    localparam logic [OPW-1:0] FN_OR   = 6'h25;
    localparam logic [OPW-1:0] FN_XOR  = 6'h26;
    localparam logic [OPW-1:0] FN_SLT  = 6'h2A;
    localparam logic [OPW-1:0] FN_SLTU = 6'h2B;

    typedef enum logic [2:0] {
        ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB
    } state_t;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT, ALU_SLTU
    } alu_op_t;

    typedef enum logic [1:0] {
        PC_SEQ, PC_BRANCH, PC_JUMP
    } pc_src_t;

    typedef enum logic [2:0] {
        CL_RALU, CL_IALU, CL_LOAD, CL_STORE, CL_BRANCH, CL_JUMP, CL_NOP
    } cls_t;

    typedef struct packed {
        logic    ir_load;
        logic    pc_load;
        pc_src_t pc_src;
        logic    ab_load;
        logic    alu_load;
        logic    mdr_load;
        logic    addr_from_alu;
        logic    mem_we;
        logic    rf_we;
        logic    dst_rd;
        logic    wb_from_mem;
        logic    opb_imm;
        logic    imm_zext;
        alu_op_t alu_op;
    } ctrl_t;

endpackage

// File: rtl/core_alu.sv
module core_alu
    import core_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_t      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         zero
);

    always_comb begin
        unique case (op)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_AND:  y = a & b;
            ALU_OR:   y = a | b;
            ALU_XOR:  y = a ^ b;
            ALU_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_SLTU: y = {{(W-1){1'b0}}, (a < b)};
            default:  y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
    parameter int W = 32,
    parameter int N = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [$clog2(N)-1:0] wa,
    input  logic [W-1:0]         wd,
    input  logic [$clog2(N)-1:0] ra1,
    input  logic [$clog2(N)-1:0] ra2,
    output logic [W-1:0]         rd1,
    output logic [W-1:0]         rd2
);

    localparam int AW = $clog2(N);

    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

    // R10
    zero_port1_chk: assert property (@(posedge clk) disable iff (rst)
        (ra1 == AW'(0)) |-> (rd1 == '0));

    // R10
    zero_port2_chk: assert property (@(posedge clk) disable iff (rst)
        (ra2 == AW'(0)) |-> (rd2 == '0));

endmodule

// File: rtl/core_ctrl.sv
module core_ctrl
    import core_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [OPW-1:0] opcode,
    input  logic [OPW-1:0] funct,
    input  logic           alu_zero,
    output state_t         state,
    output ctrl_t          ctl
);

    state_t state_nx;
    cls_t   cls;

    always_comb begin
        case (opcode)
            OP_RTYPE: begin
                case (funct)
                    FN_ADD, FN_SUB, FN_AND, FN_OR,
                    FN_XOR, FN_SLT, FN_SLTU: cls = CL_RALU;
                    default:                 cls = CL_NOP;
                endcase
            end
            OP_ADDI, OP_ANDI, OP_ORI, OP_XORI: cls = CL_IALU;
            OP_LOAD:                           cls = CL_LOAD;
            OP_STORE:                          cls = CL_STORE;
            OP_BEQ, OP_BNE:                    cls = CL_BRANCH;
            OP_JUMP:                           cls = CL_JUMP;
            default:                           cls = CL_NOP;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_FETCH;
        else     state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH:  state_nx = ST_DECODE;
            ST_DECODE: state_nx = (cls == CL_NOP) ? ST_FETCH : ST_EXEC;
            ST_EXEC: begin
                unique case (cls)
                    CL_RALU, CL_IALU:   state_nx = ST_WB;
                    CL_LOAD, CL_STORE:  state_nx = ST_MEM;
                    default:            state_nx = ST_FETCH;
                endcase
            end
            ST_MEM:    state_nx = (cls == CL_LOAD) ? ST_WB : ST_FETCH;
            ST_WB:     state_nx = ST_FETCH;
            default:   state_nx = ST_FETCH;
        endcase
    end

    // Outputs
    always_comb begin
        ctl        = '0;
        ctl.pc_src = PC_SEQ;
        ctl.alu_op = ALU_ADD;
        unique case (state)
            ST_FETCH: begin
                ctl.ir_load = 1'b1;
                ctl.pc_load = 1'b1;
            end
            ST_DECODE: begin
                ctl.ab_load = 1'b1;
            end
            ST_EXEC: begin
                ctl.alu_load = 1'b1;
                unique case (cls)
                    CL_RALU: begin
                        case (funct)
                            FN_SUB:  ctl.alu_op = ALU_SUB;
                            FN_AND:  ctl.alu_op = ALU_AND;
                            FN_OR:   ctl.alu_op = ALU_OR;
                            FN_XOR:  ctl.alu_op = ALU_XOR;
                            FN_SLT:  ctl.alu_op = ALU_SLT;
                            FN_SLTU: ctl.alu_op = ALU_SLTU;
                            default: ctl.alu_op = ALU_ADD;
                        endcase
                    end
                    CL_IALU: begin
                        ctl.opb_imm = 1'b1;
                        case (opcode)
                            OP_ANDI: begin ctl.alu_op = ALU_AND; ctl.imm_zext = 1'b1; end
                            OP_ORI:  begin ctl.alu_op = ALU_OR;  ctl.imm_zext = 1'b1; end
                            OP_XORI: begin ctl.alu_op = ALU_XOR; ctl.imm_zext = 1'b1; end
                            default: ctl.alu_op = ALU_ADD;
                        endcase
                    end
                    CL_LOAD, CL_STORE: begin
                        ctl.opb_imm = 1'b1;
                    end
                    CL_BRANCH: begin
                        ctl.alu_op  = ALU_SUB;
                        ctl.pc_src  = PC_BRANCH;
                        ctl.pc_load = (opcode == OP_BEQ) ? alu_zero : !alu_zero;
                    end
                    CL_JUMP: begin
                        ctl.pc_src  = PC_JUMP;
                        ctl.pc_load = 1'b1;
                    end
                    default: ;
                endcase
            end
            ST_MEM: begin
                ctl.addr_from_alu = 1'b1;
                ctl.mem_we        = (cls == CL_STORE);
                ctl.mdr_load      = (cls == CL_LOAD);
            end
            ST_WB: begin
                ctl.rf_we       = 1'b1;
                ctl.dst_rd      = (cls == CL_RALU);
                ctl.wb_from_mem = (cls == CL_LOAD);
            end
            default: ;
        endcase
    end

    // R2
    fetch_to_decode_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH) |=> (state == ST_DECODE));

    // R2
    wb_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WB) |=> (state == ST_FETCH));

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state == ST_FETCH));

    // R3
    write_in_mem_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.mem_we |-> (state == ST_MEM));

endmodule

// File: rtl/mc_core.sv
module mc_core
    import core_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            mem_we
);

    state_t          state;
    ctrl_t           ctl;
    logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, alu_q, mdr_q;
    logic [XLEN-1:0] rd1, rd2, alu_y, opb, imm_sext, imm_zext, imm_ext;
    logic [XLEN-1:0] rf_wd;
    logic [RAW-1:0]  rf_wa;
    logic            alu_zero;
    logic            unused_shamt;

    assign unused_shamt = ^ir_q[10:6];

    core_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .opcode   (ir_q[31:26]),
        .funct    (ir_q[5:0]),
        .alu_zero (alu_zero),
        .state    (state),
        .ctl      (ctl)
    );

    core_regfile #(.W(XLEN), .N(NREG)) u_rf (
        .clk (clk),
        .rst (rst),
        .we  (ctl.rf_we),
        .wa  (rf_wa),
        .wd  (rf_wd),
        .ra1 (ir_q[25:21]),
        .ra2 (ir_q[20:16]),
        .rd1 (rd1),
        .rd2 (rd2)
    );

    assign imm_sext = {{(XLEN-IMMW){ir_q[IMMW-1]}}, ir_q[IMMW-1:0]};
    assign imm_zext = {{(XLEN-IMMW){1'b0}}, ir_q[IMMW-1:0]};
    assign imm_ext  = ctl.imm_zext ? imm_zext : imm_sext;
    assign opb      = ctl.opb_imm ? imm_ext : b_q;

    core_alu #(.W(XLEN)) u_alu (
        .op   (ctl.alu_op),
        .a    (a_q),
        .b    (opb),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign rf_wa = ctl.dst_rd ? ir_q[15:11] : ir_q[20:16];
    assign rf_wd = ctl.wb_from_mem ? mdr_q : alu_q;

    assign mem_addr  = ctl.addr_from_alu ? alu_q : pc_q;
    assign mem_wdata = b_q;
    assign mem_we    = ctl.mem_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else if (ctl.pc_load) begin
            unique case (ctl.pc_src)
                PC_SEQ:    pc_q <= pc_q + XLEN'(4);
                PC_BRANCH: pc_q <= pc_q + {imm_sext[XLEN-3:0], 2'b00};
                PC_JUMP:   pc_q <= {pc_q[XLEN-1:JIDXW+2], ir_q[JIDXW-1:0], 2'b00};
                default:   pc_q <= pc_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (ctl.ir_load)  ir_q  <= mem_rdata;
        if (ctl.ab_load)  begin a_q <= rd1; b_q <= rd2; end
        if (ctl.alu_load) alu_q <= alu_y;
        if (ctl.mdr_load) mdr_q <= mem_rdata;
    end

    // R1
    reset_pc_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc_q == '0));

    // R12
    ir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state != ST_FETCH) |=> $stable(ir_q));

    // R3
    fetch_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH) |-> (mem_addr == pc_q));

    // R2
    pc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DECODE || state == ST_MEM || state == ST_WB) |=> $stable(pc_q));

    // R5
    slt_bool_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.alu_op == ALU_SLT || ctl.alu_op == ALU_SLTU) |-> (alu_y[XLEN-1:1] == '0));

endmodule

// File: tb/test_mc_core.sv
module test_mc_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we;

    always #10 clk = ~clk;

    mc_core i_mc_core (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we)
    );

    logic [31:0] prog [0:255];
    logic [31:0] ram  [0:255];

    assign mem_rdata = ram[mem_addr[9:2]];

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 256; k++) ram[k] <= prog[k];
        end else if (mem_we) begin
            ram[mem_addr[9:2]] <= mem_wdata;
        end
    end

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(logic [5:0] fn, logic [4:0] rd, logic [4:0] rs, logic [4:0] rt);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_j(logic [25:0] idx);
        return {6'h02, idx};
    endfunction

    function automatic logic [31:0] ref_r(logic [5:0] fn, logic [31:0] a, logic [31:0] b);
        case (fn)
            6'h20:   return a + b;
            6'h22:   return a - b;
            6'h24:   return a & b;
            6'h25:   return a | b;
            6'h26:   return a ^ b;
            6'h2A:   return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: return (a < b) ? 32'd1 : 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] ref_i(logic [5:0] op, logic [31:0] a, logic [15:0] imm);
        logic [31:0] se, ze;
        se = {{16{imm[15]}}, imm};
        ze = {16'h0000, imm};
        case (op)
            6'h08:   return a + se;
            6'h0C:   return a & ze;
            6'h0D:   return a | ze;
            default: return a ^ ze;
        endcase
    endfunction

    task automatic clear_prog();
        for (int k = 0; k < 256; k++) prog[k] = 32'h0;
        prog[66] = 32'hDEAD_BEEF;
    endtask

    // Runs the loaded program from reset; the final store targets byte address 0x108.
    task automatic run_prog(input string tag, input logic [31:0] exp_val, input int exp_cyc);
        int          first;
        logic [31:0] waddr;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst   = 1'b0;
        first = -1;
        waddr = 32'h0;
        for (int c = 0; c < 200; c++) begin
            if (mem_we && first < 0) begin
                first = c;
                waddr = mem_addr;
            end
            if (first >= 0 && c > first + 1) break;
            @(negedge clk);
        end
        check(tag, ram[66], exp_val);
        if (exp_cyc >= 0) check({"R2 cycle of store, ", tag}, 32'(first), 32'(exp_cyc));
        check({"R3 store address, ", tag}, waddr, 32'h108);
    endtask

    logic [31:0] vals [8];
    logic [5:0]  fns  [7];
    logic [5:0]  iops [4];
    logic [15:0] imms [6];

    initial begin
        vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001;
        vals[2] = 32'h7FFF_FFFF; vals[3] = 32'h8000_0000;
        vals[4] = 32'hFFFF_FFFF; vals[5] = 32'h1234_5678;
        vals[6] = 32'h0000_0005; vals[7] = 32'hFFFF_FFFB;
        fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25;
        fns[4] = 6'h26; fns[5] = 6'h2A; fns[6] = 6'h2B;
        iops[0] = 6'h08; iops[1] = 6'h0C; iops[2] = 6'h0D; iops[3] = 6'h0E;
        imms[0] = 16'h0000; imms[1] = 16'h0001; imms[2] = 16'h7FFF;
        imms[3] = 16'h8000; imms[4] = 16'hFFFF; imms[5] = 16'h1234;

        clear_prog();
        // R1: reset state seen at the port while reset is held
        repeat (3) @(negedge clk);
        check("R1 reset address", mem_addr, 32'h0);
        check("R1 reset write strobe", {31'h0, mem_we}, 32'h0);

        // R4 / R5: every R-type operation over all operand pairs
        for (int f = 0; f < 7; f++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    clear_prog();
                    prog[0]  = enc_i(6'h23, 5'd0, 5'd1, 16'h0100);
                    prog[1]  = enc_i(6'h23, 5'd0, 5'd2, 16'h0104);
                    prog[2]  = enc_r(fns[f], 5'd3, 5'd1, 5'd2);
                    prog[3]  = enc_i(6'h2B, 5'd0, 5'd3, 16'h0108);
                    prog[4]  = enc_j(26'd4);
                    prog[64] = vals[i];
                    prog[65] = vals[j];
                    run_prog((fns[f] == 6'h2A || fns[f] == 6'h2B) ? "R5 set-less-than" : "R4 R-type result",
                             ref_r(fns[f], vals[i], vals[j]), 17);
                end
            end
        end

        // R6: immediate operations, extension per opcode
        for (int o = 0; o < 4; o++) begin
            for (int i = 0; i < 8; i++) begin
                for (int m = 0; m < 6; m++) begin
                    clear_prog();
                    prog[0]  = enc_i(6'h23, 5'd0, 5'd1, 16'h0100);
                    prog[1]  = enc_i(iops[o], 5'd1, 5'd3, imms[m]);
                    prog[2]  = enc_i(6'h2B, 5'd0, 5'd3, 16'h0108);
                    prog[3]  = enc_j(26'd3);
                    prog[64] = vals[i];
                    run_prog("R6 immediate result", ref_i(iops[o], vals[i], imms[m]), 12);
                end
            end
        end

        // R8: taken and not-taken branches, both senses
        for (int s = 0; s < 2; s++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    logic taken;
                    taken = (s == 0) ? (vals[i] == vals[j]) : (vals[i] != vals[j]);
                    clear_prog();
                    prog[0]  = enc_i(6'h23, 5'd0, 5'd1, 16'h0100);
                    prog[1]  = enc_i(6'h23, 5'd0, 5'd2, 16'h0104);
                    prog[2]  = enc_i(6'h08, 5'd0, 5'd3, 16'h0007);
                    prog[3]  = enc_i((s == 0) ? 6'h04 : 6'h05, 5'd1, 5'd2, 16'h0001);
                    prog[4]  = enc_i(6'h08, 5'd0, 5'd3, 16'h0001);
                    prog[5]  = enc_i(6'h2B, 5'd0, 5'd3, 16'h0108);
                    prog[6]  = enc_j(26'd6);
                    prog[64] = vals[i];
                    prog[65] = vals[j];
                    run_prog("R8 branch outcome", taken ? 32'd7 : 32'd1, taken ? 20 : 24);
                end
            end
        end

        // R8 / R6: backward branch loop with negative immediates, 3 passes adding 5
        clear_prog();
        prog[0] = enc_i(6'h08, 5'd0, 5'd1, 16'h0003);
        prog[1] = enc_i(6'h08, 5'd0, 5'd2, 16'h0000);
        prog[2] = enc_i(6'h08, 5'd2, 5'd2, 16'h0005);
        prog[3] = enc_i(6'h08, 5'd1, 5'd1, 16'hFFFF);
        prog[4] = enc_i(6'h05, 5'd1, 5'd0, 16'hFFFD);
        prog[5] = enc_i(6'h2B, 5'd0, 5'd2, 16'h0108);
        prog[6] = enc_j(26'd6);
        run_prog("R8 backward loop", 32'd15, -1);

        // R7 R12: load and store with negative offsets from a base register
        clear_prog();
        prog[0]  = enc_i(6'h08, 5'd0, 5'd5, 16'h0120);
        prog[1]  = enc_i(6'h23, 5'd5, 5'd1, 16'hFFE0);
        prog[2]  = enc_i(6'h2B, 5'd5, 5'd1, 16'hFFE8);
        prog[3]  = enc_j(26'd3);
        prog[64] = 32'hA5C3_0F96;
        run_prog("R7 R12 load/store offset", 32'hA5C3_0F96, 12);

        // R9: jump over an instruction
        clear_prog();
        prog[0] = enc_i(6'h08, 5'd0, 5'd3, 16'h0001);
        prog[1] = enc_j(26'd3);
        prog[2] = enc_i(6'h08, 5'd0, 5'd3, 16'h0002);
        prog[3] = enc_i(6'h2B, 5'd0, 5'd3, 16'h0108);
        prog[4] = enc_j(26'd4);
        run_prog("R9 jump target", 32'd1, 10);

        // R10: writes to register 0 are dropped
        clear_prog();
        prog[0]  = enc_i(6'h23, 5'd0, 5'd1, 16'h0100);
        prog[1]  = enc_i(6'h08, 5'd1, 5'd0, 16'h0005);
        prog[2]  = enc_r(6'h20, 5'd0, 5'd1, 5'd1);
        prog[3]  = enc_i(6'h2B, 5'd0, 5'd0, 16'h0108);
        prog[4]  = enc_j(26'd4);
        prog[64] = 32'h1234_5678;
        run_prog("R10 register 0", 32'h0, 16);

        // R11: undefined opcode and undefined function act as no-ops
        clear_prog();
        prog[0] = enc_i(6'h08, 5'd0, 5'd3, 16'h0009);
        prog[1] = 32'hFC00_0000;
        prog[2] = enc_r(6'h3F, 5'd3, 5'd1, 5'd1);
        prog[3] = enc_i(6'h2B, 5'd0, 5'd3, 16'h0108);
        prog[4] = enc_j(26'd4);
        run_prog("R11 undefined encodings", 32'd9, 11);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule